// File: doc/BRIEF.md
# Per-Pixel Direct/Indexed Color Selector

This block sits in the scan-out path of a mixed-depth framebuffer. Every pixel arrives with three words fetched in parallel: an 8-bit palette index, a 32-bit true-color word and a 32-bit control word. The control word decides, pixel by pixel, whether the 24-bit output color is taken straight from the true-color word or looked up in a 256-entry palette RAM that belongs to another block.

The palette RAM is read through a synchronous port with one cycle of latency. The true-color value is registered once so that both paths leave the block in step with their pixel. A valid/ready handshake runs on each side. A stall at the output freezes the single pipeline stage and pushes back on the input. The block counts accepted pixels against a parameterised active area whose width is at most 1024 columns, the fixed line stride. It flags the last pixel of each line and of each frame.

Top module: `pix_color_mux`

## Requirements
- R1: When bits 31:24 of the control word equal 0x03, the output color is the true-color word's bits 23:0, with bits 23:16 in out_color[23:16], bits 15:8 in out_color[15:8] and bits 7:0 in out_color[7:0].
- R2: Bits 31:24 of the true-color word have no effect on the output color.
- R3: For any other value of control bits 31:24, the output color is the palette entry addressed by the pixel's index, whatever the lower 24 control bits hold.
- R4: A pixel accepted on a clock edge (in_valid and in_ready high) is presented with out_valid high in the next cycle. Pixels leave in the order they were accepted.
- R5: While out_valid is high and out_ready is low, in_ready is low. In the next cycle out_valid, out_color, out_eol and out_eof are unchanged.
- R6: pal_rd_en is high exactly in the cycles where a pixel is accepted, and pal_addr then carries that pixel's index.
- R7: out_eol is high exactly on the pixel in the last active column (column WIDTH-1) of each line.
- R8: out_eof is high exactly on the last pixel of the last active line. The next accepted pixel is column 0 of line 0.
- R9: After reset, out_valid is low, in_ready is high, and the first accepted pixel is column 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take a pixel |
| in_index | input | 8 | Palette index from the 8-bit plane |
| in_deep | input | 32 | Word from the 24-bit plane |
| in_ctrl | input | 32 | Word from the control plane |
| pal_rd_en | output | 1 | Palette read strobe |
| pal_addr | output | 8 | Palette read address |
| pal_rdata | input | 24 | Palette data, one cycle after the strobe |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Downstream can take a pixel |
| out_color | output | 24 | Resolved 24-bit color |
| out_eol | output | 1 | Last pixel of a line |
| out_eof | output | 1 | Last pixel of a frame |

## Verification
The assertions assume that the palette RAM returns its data one cycle after pal_rd_en and keeps it unchanged until the next strobe. Without that, the stall-stability property on out_color would not hold for palette pixels. The bench models the RAM in exactly this way, with every entry a computable function of its address. It also assumes the pixel stream is frame-aligned from reset. The bench starts counting at the first accepted pixel and never discards a pixel mid-frame. It applies random idle gaps and random output backpressure, but it never withdraws a pixel it has offered, so the handshake stays legal.

// File: rtl/pix_color_mux.sv
module pix_color_mux #(
  parameter int WIDTH = 640,
  parameter int HEIGHT = 480,
  parameter logic [7:0] DIRECT_CODE = 8'h03
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_index,
  input  logic [31:0] in_deep,
  input  logic [31:0] in_ctrl,
  output logic        pal_rd_en,
  output logic [7:0]  pal_addr,
  input  logic [23:0] pal_rdata,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [23:0] out_color,
  output logic        out_eol,
  output logic        out_eof
);
  localparam int MAX_COLS = 1024;
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int RW = (HEIGHT > 1) ? $clog2(HEIGHT) : 1;

  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic          s_valid, s_direct, s_eol, s_eof;
  logic [23:0]   s_rgb;

  wire take     = in_valid & in_ready;
  wire last_col = (col == CW'(WIDTH - 1));
  wire last_row = (row == RW'(HEIGHT - 1));

  assign in_ready  = ~s_valid | out_ready;
  assign pal_rd_en = take;
  assign pal_addr  = in_index;
  assign out_valid = s_valid;
  assign out_color = s_direct ? s_rgb : pal_rdata;
  assign out_eol   = s_eol;
  assign out_eof   = s_eof;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_valid  <= 1'b0;
      s_direct <= 1'b0;
      s_rgb    <= '0;
      s_eol    <= 1'b0;
      s_eof    <= 1'b0;
      col      <= '0;
      row      <= '0;
    end else if (in_ready) begin
      s_valid <= in_valid;
      if (in_valid) begin
        s_direct <= (in_ctrl[31:24] == DIRECT_CODE);
        s_rgb    <= in_deep[23:0];
        s_eol    <= last_col;
        s_eof    <= last_col & last_row;
        col      <= last_col ? '0 : col + 1'b1;
        if (last_col) row <= last_row ? '0 : row + 1'b1;
      end
    end
  end

  initial a_r7_geometry: assert (WIDTH >= 2 && WIDTH <= MAX_COLS && HEIGHT >= 2);

  a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_color)
                                   && $stable(out_eol) && $stable(out_eof)));

  a_r5_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r8_eof_on_eol: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eof) |-> out_eol);

  a_r6_read_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    pal_rd_en |-> (in_valid && in_ready));
endmodule

// File: tb/pix_color_mux_test.sv
`timescale 1ns/1ps
module pix_color_mux_test;
  localparam int W = 4;
  localparam int H = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, in_valid, in_ready, pal_rd_en, out_valid, out_ready, out_eol, out_eof;
  logic [7:0]  in_index, pal_addr;
  logic [31:0] in_deep, in_ctrl;
  logic [23:0] pal_rdata, out_color;

  pix_color_mux #(.WIDTH(W), .HEIGHT(H)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_index(in_index), .in_deep(in_deep), .in_ctrl(in_ctrl),
    .pal_rd_en(pal_rd_en), .pal_addr(pal_addr), .pal_rdata(pal_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_color(out_color),
    .out_eol(out_eol), .out_eof(out_eof));

  function automatic logic [23:0] palf(input logic [7:0] a);
    logic [7:0] t;
    t = a * 8'd3 + 8'd1;
    return {a, ~a, t};
  endfunction

  always_ff @(posedge clk) if (pal_rd_en) pal_rdata <= palf(pal_addr);

  int checks = 0, failures = 0;
  logic [23:0] exp_c [4];
  logic        exp_l [4], exp_f [4];
  string       exp_t [4];
  int wr = 0, rd = 0, pix_n = 0;
  bit last_acc = 0, prev_stall = 0;
  logic [23:0] pv_c; logic pv_l, pv_f;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [7:0] ix, input logic [31:0] dp,
                      input logic [31:0] ct, input int rdy, output bit acc);
    @(negedge clk);
    in_valid = v; in_index = ix; in_deep = dp; in_ctrl = ct;
    out_ready = (($urandom % 100) < rdy);
    #1;
    if (last_acc) chk(out_valid, "R4 valid after accept", out_valid, 1);
    if (prev_stall)
      chk(out_valid && out_color == pv_c && out_eol == pv_l && out_eof == pv_f,
          "R5 held output", {out_valid, out_eol, out_eof, 5'd0, out_color},
          {1'b1, pv_l, pv_f, 5'd0, pv_c});
    prev_stall = out_valid && !out_ready;
    if (prev_stall) begin
      chk(!in_ready, "R5 ready low in stall", in_ready, 0);
      pv_c = out_color; pv_l = out_eol; pv_f = out_eof;
    end
    chk(pal_rd_en == (v && in_ready), "R6 read strobe", pal_rd_en, v && in_ready);
    if (pal_rd_en) chk(pal_addr == ix, "R6 read address", pal_addr, ix);
    if (out_valid && out_ready) begin
      chk(rd != wr, "R4 unexpected pixel", 1, 0);
      chk(out_color == exp_c[rd%4], exp_t[rd%4], out_color, exp_c[rd%4]);
      chk(out_eol == exp_l[rd%4], "R7 end of line", out_eol, exp_l[rd%4]);
      chk(out_eof == exp_f[rd%4], "R8 end of frame", out_eof, exp_f[rd%4]);
      rd++;
    end
    acc = v && in_ready;
    if (acc) begin
      if (ct[31:24] == 8'h03) begin
        exp_c[wr%4] = dp[23:0];
        exp_t[wr%4] = (dp[31:24] != 0) ? "R2 top byte ignored" : "R1 direct color";
      end else begin
        exp_c[wr%4] = palf(ix);
        exp_t[wr%4] = "R3 palette color";
      end
      exp_l[wr%4] = (pix_n % W) == W - 1;
      exp_f[wr%4] = (pix_n % (W * H)) == W * H - 1;
      wr++; pix_n++;
    end
    last_acc = acc;
  endtask

  task automatic send(input logic [7:0] ix, input logic [31:0] dp, input logic [31:0] ct,
                      input int rdy, input int idle_pct);
    bit acc;
    if (($urandom % 100) < idle_pct) step(0, 0, 0, 0, rdy, acc);
    acc = 0;
    while (!acc) step(1, ix, dp, ct, rdy, acc);
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog R4 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit acc;
    rst_n = 0; in_valid = 0; in_index = 0; in_deep = 0; in_ctrl = 0; out_ready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && in_ready, "R9 reset state", {out_valid, in_ready}, 2'b01);
    rst_n = 1;
    for (int c = 0; c < 256; c++)
      send(8'(c), {~8'(c), 8'(c), 8'(c) ^ 8'h33, 8'(c) + 8'd7}, {8'(c), 24'h5a5a5a}, 100, 0);
    for (int i = 0; i < 128; i++)
      send(8'(i), {8'(i) | 8'h80, 8'(i * 5), 8'(i * 7), 8'(i * 11)}, 32'h03000000 | i, 60, 30);
    for (int i = 0; i < 256; i++)
      send(8'(i), 32'hffffffff, (i % 3 == 0) ? 32'h00000003 : 32'h00030303, 50, 20);
    for (int i = 0; i < 200; i++)
      send(8'(i * 13), {8'hc3, 8'(i), 8'(~i), 8'(i * 9)},
           ((i % 4) < 2) ? 32'h03ffffff : {8'(i % 4) + 8'h02, 24'h0}, 40, 40);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 100, acc);
    chk(rd == wr, "R4 all pixels delivered", rd, wr);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule